// File: doc/BRIEF.md
# Interrupt Event Notification Trigger

This block turns interrupt source events into notification writes. Each accepted event carries a source number. The block queues it in a small FIFO. When the event reaches the head, the block forms one 64-bit memory write. The write address comes from a programmable notify-address register with its valid bit stripped. The write data is a fixed trigger flag combined with a programmable source offset and the source number. A write is presented on a valid/ready output only while the notify-address register is marked valid. Otherwise the head event is discarded.

The block also holds the configuration used by the surrounding interrupt logic. A control register carries a method bit that freezes the per-source level register, and a self-clearing source-reset request. A window-base register emits a map or unmap pulse whenever its valid bit changes. A per-source level register tracks asserted sources using MSB-first bit numbering. Software reaches these registers through 8-byte memory-mapped accesses. A separate configuration port can only load the block's own base address, and it reads back all ones.

Top module: `irq_notify_top`

## Requirements
- R1: After reset the four mapped registers (control, window base, notify address, source offset) and the level register are zero, no notification is presented, no pulse is active, and the base address is the reset base masked with the base mask, with bit 0 set.
- R2: Byte offsets 0x58 (control), 0x60 (window base), 0x68 (notify address) and 0x70 (source offset) are written and read back as whole 64-bit words. Offsets 0x20 and 0x28 read as zero and ignore writes. Every other offset, including misaligned ones, reads as all ones.
- R3: A notification has address = notify-address register with bit 0 cleared, and data = TRIG_FLAG | (source-offset register >> 32) | source number. Both are formed from the register values held before any write landing in the same cycle as the pop. Events with a source number of NUM_SRC or above are ignored.
- R4: While bit 0 of the notify-address register is 0, no notification is presented, and events reaching the FIFO head are discarded.
- R5: A presented notification keeps its valid, address and data stable until ready is seen. Events are delivered in arrival order. An event arriving while the FIFO holds FIFO_DEPTH entries is dropped.
- R6: A level update for source n < NUM_SRC sets or clears bit 63-n (MSB-first bit n) of the level register, visible on the next cycle. Updates for n >= NUM_SRC are ignored.
- R7: While bit 63 (method bit) of the control register is set, level updates are ignored. The check uses the control value held before a same-cycle control write.
- R8: A control write with bit 62 set produces a one-cycle source-reset pulse in the following cycle, and the written value is still stored.
- R9: A window-base write that changes bit 0 from 0 to 1 produces a one-cycle map pulse, with the written value (bit 0 cleared) on the window address. A change from 1 to 0 produces an unmap pulse, with the previous value (bit 0 cleared) on the window address. A write that leaves bit 0 unchanged produces no pulse.
- R10: Configuration-port reads return all ones. A configuration write to index 0x0A loads the base address with the data masked by the base mask, keeping bit 0. Writes to any other index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Memory-mapped write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| cfg_wr_en | input | 1 | Configuration-port write strobe |
| cfg_idx | input | 5 | Configuration register index |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data (all ones) |
| lvl_we | input | 1 | Level update strobe |
| lvl_idx | input | SRC_W | Source number of the level update |
| lvl_val | input | 1 | New level (1 asserted) |
| evt_valid | input | 1 | Source event strobe |
| evt_src | input | SRC_W | Source number of the event |
| ntf_valid | output | 1 | Notification write presented |
| ntf_ready | input | 1 | Notification write accepted |
| ntf_addr | output | 64 | Notification write address |
| ntf_data | output | 64 | Notification write data |
| src_reset | output | 1 | One-cycle source-state reset request |
| win_map | output | 1 | One-cycle window map pulse |
| win_unmap | output | 1 | One-cycle window unmap pulse |
| win_addr | output | 64 | Window address for the map/unmap pulse |
| lvl_state | output | 64 | Level register |
| base_addr | output | 64 | Block base address register |

## Verification
Two collisions are provoked. In the first, the FIFO head is moved into the output stage on the same edge that a memory-mapped write changes the notify address. The event is queued one cycle earlier, so its pop lines up with the write, and the captured address must be the old one while the next event carries the new one. In the second, a control write that sets the method bit lands together with a level update. The update must still take effect, and only a later update is refused. A behavioural model in the bench tracks both orderings, and every cycle is compared against it.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

    localparam int DW        = 64;
    localparam int CFG_IDX_W = 5;

    // Memory-mapped byte offsets
    localparam int unsigned OFF_CTL  = 32'h58;
    localparam int unsigned OFF_WIN  = 32'h60;
    localparam int unsigned OFF_NTF  = 32'h68;
    localparam int unsigned OFF_OFS  = 32'h70;
    localparam int unsigned OFF_RZ0  = 32'h20;
    localparam int unsigned OFF_RZ1  = 32'h28;

    localparam logic [CFG_IDX_W-1:0] CFG_BASE_IDX = 5'h0A;

    // Control bits, LSB-first positions
    localparam int CTL_METHOD_BIT = 63;
    localparam int CTL_SRCRST_BIT = 62;

    localparam logic [DW-1:0] ALL_ONES = '1;

    typedef enum logic [2:0] {
        SEL_CTL,
        SEL_WIN,
        SEL_NTF,
        SEL_OFS,
        SEL_ZERO,
        SEL_NONE
    } rsel_e;

    function automatic rsel_e decode_off(input int unsigned off);
        case (off)
            OFF_CTL:          return SEL_CTL;
            OFF_WIN:          return SEL_WIN;
            OFF_NTF:          return SEL_NTF;
            OFF_OFS:          return SEL_OFS;
            OFF_RZ0, OFF_RZ1: return SEL_ZERO;
            default:          return SEL_NONE;
        endcase
    endfunction

    // MSB-first bit n as an LSB-first mask
    function automatic logic [DW-1:0] msb0_mask(input int unsigned n);
        return 64'd1 << (DW - 1 - n);
    endfunction

endpackage

// File: rtl/irqn_regs.sv
module irqn_regs
    import irqn_pkg::*;
#(
    parameter int ADDR_W            = 8,
    parameter int NUM_SRC           = 14,
    parameter int SRC_W             = 4,
    parameter logic [63:0] BASE_MASK  = 64'h00FF_FFFF_FFF0_0000,
    parameter logic [63:0] BASE_RESET = 64'h0000_0006_0300_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 cfg_wr_en,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 lvl_we,
    input  logic [SRC_W-1:0]     lvl_idx,
    input  logic                 lvl_val,
    output logic [DW-1:0]        ntf_reg,
    output logic [31:0]          ofs_hi,
    output logic [DW-1:0]        lvl_reg,
    output logic [DW-1:0]        base_reg,
    output logic                 src_rst,
    output logic                 map_p,
    output logic                 unmap_p,
    output logic [DW-1:0]        map_addr
);

    localparam logic [DW-1:0] BASE_KEEP = BASE_MASK | 64'd1;
    localparam logic [DW-1:0] VALID_CLR = ~64'd1;

    typedef struct packed {
        logic [DW-1:0] ctl;
        logic [DW-1:0] win;
        logic [DW-1:0] ntf;
        logic [DW-1:0] ofs;
        logic [DW-1:0] lvl;
        logic [DW-1:0] base;
        logic [DW-1:0] waddr;
        logic          rst_p;
        logic          map;
        logic          unmap;
    } regs_t;

    localparam regs_t REGS_RST = '{
        ctl: '0, win: '0, ntf: '0, ofs: '0, lvl: '0,
        base: (BASE_RESET & BASE_MASK) | 64'd1,
        waddr: '0, rst_p: 1'b0, map: 1'b0, unmap: 1'b0
    };

    regs_t         r_d, r_q;
    rsel_e         sel;
    logic          lvl_ok;
    logic [DW-1:0] lvl_mask;

    always_comb begin
        sel      = decode_off(32'(addr));
        lvl_ok   = lvl_we && !r_q.ctl[CTL_METHOD_BIT] && (32'(lvl_idx) < 32'(NUM_SRC));
        lvl_mask = msb0_mask(32'(lvl_idx));

        r_d       = r_q;
        r_d.rst_p = 1'b0;
        r_d.map   = 1'b0;
        r_d.unmap = 1'b0;

        if (wr_en) begin
            case (sel)
                SEL_CTL: begin
                    r_d.ctl   = wdata;
                    r_d.rst_p = wdata[CTL_SRCRST_BIT];
                end
                SEL_WIN: begin
                    r_d.win = wdata;
                    if (wdata[0] && !r_q.win[0]) begin
                        r_d.map   = 1'b1;
                        r_d.waddr = wdata & VALID_CLR;
                    end else if (!wdata[0] && r_q.win[0]) begin
                        r_d.unmap = 1'b1;
                        r_d.waddr = r_q.win & VALID_CLR;
                    end
                end
                SEL_NTF: r_d.ntf = wdata;
                SEL_OFS: r_d.ofs = wdata;
                default: ;
            endcase
        end

        if (lvl_ok) begin
            if (lvl_val) r_d.lvl = r_q.lvl | lvl_mask;
            else         r_d.lvl = r_q.lvl & ~lvl_mask;
        end

        if (cfg_wr_en && (cfg_idx == CFG_BASE_IDX)) begin
            r_d.base = cfg_wdata & BASE_KEEP;
        end

        case (sel)
            SEL_CTL:  rdata = r_q.ctl;
            SEL_WIN:  rdata = r_q.win;
            SEL_NTF:  rdata = r_q.ntf;
            SEL_OFS:  rdata = r_q.ofs;
            SEL_ZERO: rdata = '0;
            default:  rdata = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign ntf_reg  = r_q.ntf;
    assign ofs_hi   = r_q.ofs[63:32];
    assign lvl_reg  = r_q.lvl;
    assign base_reg = r_q.base;
    assign src_rst  = r_q.rst_p;
    assign map_p    = r_q.map;
    assign unmap_p  = r_q.unmap;
    assign map_addr = r_q.waddr;

    AST_SRCRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rst_p |-> $past(wr_en && (sel == SEL_CTL) && wdata[CTL_SRCRST_BIT])); // R8

    AST_LVL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_we && r_q.ctl[CTL_METHOD_BIT]) |=> $stable(r_q.lvl)); // R7

    AST_MAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.map |-> ($past(wr_en && (sel == SEL_WIN)) && r_q.win[0])); // R9

    AST_UNMAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.unmap |-> ($past(r_q.win[0]) && !r_q.win[0])); // R9

endmodule

// File: rtl/irqn_fifo.sv
module irqn_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fptr_t;

    fptr_t      f_d, f_q;
    logic       full;
    logic       push_ok;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        full    = (f_q.cnt == CNT_W'(DEPTH));
        empty   = (f_q.cnt == '0);
        push_ok = push && !full;

        f_d = f_q;
        if (push_ok) begin
            f_d.wp = (f_q.wp == PTR_W'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (pop) begin
            f_d.rp = (f_q.rp == PTR_W'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CNT_W'(push_ok) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // Storage array: written in place, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[f_q.wp] <= push_data;
    end

    assign head = mem_q[f_q.rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CNT_W'(DEPTH)); // R5

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (f_q.cnt != '0)); // R5

endmodule

// File: rtl/irqn_packer.sv
module irqn_packer #(
    parameter int SRC_W = 4,
    parameter logic [63:0] TRIG_FLAG = 64'h8000_0000_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty,
    input  logic [SRC_W-1:0] head,
    input  logic [63:0]      ntf_reg,
    input  logic [31:0]      ofs_hi,
    input  logic             ready,
    output logic             pop,
    output logic             valid,
    output logic [63:0]      addr,
    output logic [63:0]      data
);

    typedef struct packed {
        logic        v;
        logic [63:0] addr;
        logic [63:0] data;
    } stage_t;

    stage_t p_d, p_q;
    logic   free;
    logic   send;

    always_comb begin
        free = !p_q.v || ready;
        pop  = free && !empty;
        send = pop && ntf_reg[0];

        p_d = p_q;
        if (free) begin
            p_d.v = send;
            if (send) begin
                p_d.addr = ntf_reg & ~64'd1;
                p_d.data = TRIG_FLAG | {32'd0, ofs_hi} | 64'(head);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign valid = p_q.v;
    assign addr  = p_q.addr;
    assign data  = p_q.data;

    AST_NTF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.v && !ready) |=> (p_q.v && $stable(p_q.addr) && $stable(p_q.data))); // R5

    AST_NO_SEND_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.v) |-> $past(ntf_reg[0])); // R4

endmodule

// File: rtl/irq_notify_top.sv
module irq_notify_top
    import irqn_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_SRC    = 14,
    parameter int FIFO_DEPTH = 4,
    parameter logic [63:0] TRIG_FLAG  = 64'h8000_0000_0000_0000,
    parameter logic [63:0] BASE_MASK  = 64'h00FF_FFFF_FFF0_0000,
    parameter logic [63:0] BASE_RESET = 64'h0000_0006_0300_0000,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              cfg_wr_en,
    input  logic [4:0]        cfg_idx,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              lvl_we,
    input  logic [SRC_W-1:0]  lvl_idx,
    input  logic              lvl_val,
    input  logic              evt_valid,
    input  logic [SRC_W-1:0]  evt_src,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [63:0]       ntf_addr,
    output logic [63:0]       ntf_data,
    output logic              src_reset,
    output logic              win_map,
    output logic              win_unmap,
    output logic [63:0]       win_addr,
    output logic [63:0]       lvl_state,
    output logic [63:0]       base_addr
);

    logic [63:0]      ntf_reg;
    logic [31:0]      ofs_hi;
    logic             q_empty;
    logic             q_pop;
    logic             q_push;
    logic [SRC_W-1:0] q_head;

    assign q_push    = evt_valid && (32'(evt_src) < 32'(NUM_SRC));
    assign cfg_rdata = ALL_ONES;

    irqn_regs #(
        .ADDR_W     (ADDR_W),
        .NUM_SRC    (NUM_SRC),
        .SRC_W      (SRC_W),
        .BASE_MASK  (BASE_MASK),
        .BASE_RESET (BASE_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cfg_wr_en (cfg_wr_en),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .lvl_we    (lvl_we),
        .lvl_idx   (lvl_idx),
        .lvl_val   (lvl_val),
        .ntf_reg   (ntf_reg),
        .ofs_hi    (ofs_hi),
        .lvl_reg   (lvl_state),
        .base_reg  (base_addr),
        .src_rst   (src_reset),
        .map_p     (win_map),
        .unmap_p   (win_unmap),
        .map_addr  (win_addr)
    );

    irqn_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SRC_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (evt_src),
        .pop       (q_pop),
        .empty     (q_empty),
        .head      (q_head)
    );

    irqn_packer #(
        .SRC_W     (SRC_W),
        .TRIG_FLAG (TRIG_FLAG)
    ) u_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .empty   (q_empty),
        .head    (q_head),
        .ntf_reg (ntf_reg),
        .ofs_hi  (ofs_hi),
        .ready   (ntf_ready),
        .pop     (q_pop),
        .valid   (ntf_valid),
        .addr    (ntf_addr),
        .data    (ntf_data)
    );

endmodule

// File: tb/test_irq_notify_top.sv
module test_irq_notify_top;

    localparam int NUM_SRC = 14;
    localparam int DEPTH   = 4;
    localparam int SRC_W   = 4;
    localparam logic [63:0] TRIG  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] BMASK = 64'h00FF_FFFF_FFF0_0000;
    localparam logic [63:0] BRST  = 64'h0000_0006_0300_0000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [7:0]       reg_addr = 8'h58;
    logic [63:0]      reg_wdata = '0;
    logic [63:0]      reg_rdata;
    logic             cfg_wr_en = 1'b0;
    logic [4:0]       cfg_idx = '0;
    logic [63:0]      cfg_wdata = '0;
    logic [63:0]      cfg_rdata;
    logic             lvl_we = 1'b0;
    logic [SRC_W-1:0] lvl_idx = '0;
    logic             lvl_val = 1'b0;
    logic             evt_valid = 1'b0;
    logic [SRC_W-1:0] evt_src = '0;
    logic             ntf_valid;
    logic             ntf_ready = 1'b1;
    logic [63:0]      ntf_addr, ntf_data;
    logic             src_reset, win_map, win_unmap;
    logic [63:0]      win_addr, lvl_state, base_addr;

    irq_notify_top #(
        .ADDR_W(8), .NUM_SRC(NUM_SRC), .FIFO_DEPTH(DEPTH),
        .TRIG_FLAG(TRIG), .BASE_MASK(BMASK), .BASE_RESET(BRST)
    ) i_irq_notify_top (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_val(lvl_val),
        .evt_valid(evt_valid), .evt_src(evt_src),
        .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_addr(ntf_addr), .ntf_data(ntf_data),
        .src_reset(src_reset), .win_map(win_map), .win_unmap(win_unmap), .win_addr(win_addr),
        .lvl_state(lvl_state), .base_addr(base_addr)
    );

    int n_cmp = 0;
    int n_err = 0;

    // Behavioural reference model
    int          m_q[$];
    bit          m_ov;
    logic [63:0] m_oaddr, m_odata;
    logic [63:0] m_ctl, m_win, m_ntf, m_ofs, m_lvl, m_base, m_waddr;
    bit          m_rst, m_map, m_unmap;

    task automatic model_reset();
        m_q.delete();
        m_ov = 0; m_oaddr = '0; m_odata = '0;
        m_ctl = '0; m_win = '0; m_ntf = '0; m_ofs = '0; m_lvl = '0;
        m_base = (BRST & BMASK) | 64'd1; m_waddr = '0;
        m_rst = 0; m_map = 0; m_unmap = 0;
    endtask

    function automatic logic [63:0] m_read(input logic [7:0] a);
        case (a)
            8'h58: return m_ctl;
            8'h60: return m_win;
            8'h68: return m_ntf;
            8'h70: return m_ofs;
            8'h20, 8'h28: return 64'd0;
            default: return '1;
        endcase
    endfunction

    task automatic model_step();
        bit free = !m_ov || ntf_ready;
        int sz = m_q.size();
        bit dopop = free && (sz > 0);
        bit acc = evt_valid && (int'(evt_src) < NUM_SRC) && (sz < DEPTH);
        if (free) begin
            m_ov = 0;
            if (dopop) begin
                int h = m_q.pop_front();
                if (m_ntf[0]) begin
                    m_ov = 1;
                    m_oaddr = m_ntf & ~64'd1;
                    m_odata = TRIG | (m_ofs >> 32) | 64'(h);
                end
            end
        end
        if (acc) m_q.push_back(int'(evt_src));
        m_rst = 0; m_map = 0; m_unmap = 0;
        if (lvl_we && !m_ctl[63] && int'(lvl_idx) < NUM_SRC) begin
            if (lvl_val) m_lvl[63 - int'(lvl_idx)] = 1'b1;
            else         m_lvl[63 - int'(lvl_idx)] = 1'b0;
        end
        if (reg_wr_en) begin
            case (reg_addr)
                8'h58: begin m_ctl = reg_wdata; m_rst = reg_wdata[62]; end
                8'h60: begin
                    if (reg_wdata[0] && !m_win[0]) begin m_map = 1; m_waddr = reg_wdata & ~64'd1; end
                    else if (!reg_wdata[0] && m_win[0]) begin m_unmap = 1; m_waddr = m_win & ~64'd1; end
                    m_win = reg_wdata;
                end
                8'h68: m_ntf = reg_wdata;
                8'h70: m_ofs = reg_wdata;
                default: ;
            endcase
        end
        if (cfg_wr_en && cfg_idx == 5'h0A) m_base = cfg_wdata & (BMASK | 64'd1);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R5 ntf_valid", 64'(ntf_valid), 64'(m_ov));
        if (m_ov) begin
            chk("R3 ntf_addr", ntf_addr, m_oaddr);
            chk("R3 ntf_data", ntf_data, m_odata);
        end
        chk("R2 reg_rdata", reg_rdata, m_read(reg_addr));
        chk("R6 lvl_state", lvl_state, m_lvl);
        chk("R8 src_reset", 64'(src_reset), 64'(m_rst));
        chk("R9 win_map", 64'(win_map), 64'(m_map));
        chk("R9 win_unmap", 64'(win_unmap), 64'(m_unmap));
        if (m_map || m_unmap) chk("R9 win_addr", win_addr, m_waddr);
        chk("R10 base_addr", base_addr, m_base);
        chk("R10 cfg_rdata", cfg_rdata, '1);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) model_step();
        else       model_reset();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic ev(input int s);
        evt_valid = 1'b1; evt_src = SRC_W'(s);
        tick();
        evt_valid = 1'b0;
    endtask

    task automatic lvl(input int s, input bit v);
        lvl_we = 1'b1; lvl_idx = SRC_W'(s); lvl_val = v;
        tick();
        lvl_we = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    initial begin
        model_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 lvl_state", lvl_state, 64'd0);
        chk("R1 ntf_valid", 64'(ntf_valid), 64'd0);
        chk("R1 base_addr", base_addr, (BRST & BMASK) | 64'd1);
        chk("R1 ctl read", reg_rdata, 64'd0);

        // R2: read sweep, including a misaligned offset
        for (int a = 0; a < 8'h80; a += 8) begin reg_addr = 8'(a); tick(); end
        reg_addr = 8'h59; tick();

        // R2: write and read back
        wr(8'h58, 64'h0000_0000_0000_00F0); tick();
        wr(8'h70, 64'h0000_0030_1234_5678); tick();
        wr(8'h20, 64'hDEAD_BEEF_0000_0001); tick();
        wr(8'h28, 64'h1111_2222_3333_4444); tick();
        wr(8'h40, 64'h5555_6666_7777_8888); tick();

        // R9: window transitions
        wr(8'h60, 64'h0000_1234_5600_0001); tick();
        wr(8'h60, 64'h0000_0ABC_0000_0001); tick();
        wr(8'h60, 64'h0000_0ABC_0000_0000); tick();
        wr(8'h60, 64'h0000_0777_0000_0000); tick();

        // R3: notifications with valid set
        wr(8'h68, 64'h0000_00AB_CDEF_0101);
        ntf_ready = 1'b1;
        ev(3); ev(5); ev(13);
        repeat (4) tick();
        ev(14); ev(15);   // out-of-range sources ignored (R3)
        repeat (3) tick();

        // R5: back-pressure and overflow
        ntf_ready = 1'b0;
        for (int i = 0; i < 7; i++) ev(i + 1);
        repeat (3) tick();
        for (int k = 0; k < 20; k++) begin ntf_ready = (k % 3) != 0; tick(); end
        ntf_ready = 1'b1;
        repeat (2) tick();

        // R4: notify address invalid
        wr(8'h68, 64'h0000_0022_0000_0200);
        ev(2); ev(7);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R4 no notification", 64'(ntf_valid), 64'd0);
        end

        // R3: pop and notify write in the same cycle
        wr(8'h68, 64'h0000_0044_0000_1001);
        ev(9);
        wr(8'h68, 64'h0000_0055_0000_2001);
        ev(4);
        repeat (3) tick();
        // event pushed on the same edge as a write: pop sees the new value
        evt_valid = 1'b1; evt_src = 4'd6;
        reg_wr_en = 1'b1; reg_addr = 8'h68; reg_wdata = 64'h0000_0066_0000_3001;
        tick();
        evt_valid = 1'b0; reg_wr_en = 1'b0;
        repeat (3) tick();

        // R6: level tracking
        lvl(0, 1); lvl(13, 1); lvl(14, 1); lvl(15, 1); lvl(0, 0); lvl(7, 1);
        tick();

        // R7: method bit set together with a level update (old value used)
        lvl_we = 1'b1; lvl_idx = 4'd5; lvl_val = 1'b1;
        reg_wr_en = 1'b1; reg_addr = 8'h58; reg_wdata = 64'h8000_0000_0000_0000;
        tick();
        lvl_we = 1'b0; reg_wr_en = 1'b0;
        lvl(6, 1); lvl(13, 0);
        chk("R7 level frozen", lvl_state, m_lvl);
        chk("R7 level bit 6 clear", 64'(lvl_state[57]), 64'd0);

        // R8: source reset pulse, value stored
        wr(8'h58, 64'h4000_0000_0000_0003);
        chk("R8 pulse", 64'(src_reset), 64'd1);
        tick();
        chk("R8 pulse ends", 64'(src_reset), 64'd0);
        lvl(6, 1);
        wr(8'h58, 64'hC000_0000_0000_0000);
        tick();

        // R10: configuration port
        cfg_wr_en = 1'b1; cfg_idx = 5'h0A; cfg_wdata = 64'hFFFF_0001_2345_6789;
        tick();
        cfg_idx = 5'h0B; cfg_wdata = 64'h0000_0000_0000_0000;
        tick();
        cfg_idx = 5'h00;
        tick();
        cfg_wr_en = 1'b0;
        tick();

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

endmodule